// File: doc/BRIEF.md
# Dual-Issue Pairing Decision Logic

This block decides, once per cycle, how many of the two oldest queued instructions an in-order, two-wide integer and floating-point pipeline may issue. It takes the class code of the older and of the younger instruction, a flag raised when the younger reads the older's destination, and two stall inputs. It returns an issue count (none, older only, or both) and a slot mask for each instruction. Slot A is the first execution slot and slot B is the second.

Each class follows its own slot rule. Some classes may use either slot. Some use slot A only, some only pair as the younger member, and some reserve both slots. The three-word and four-word block transfers also hold slots during the cycle after they issue, and issue is blocked in that cycle. By default the decision is combinational. Setting the parameter `REG_OUT` moves the three decision outputs behind one register stage.

Top module: `dual_issue_pair`

## Requirements
- R1: While `rst_n` is low, `issue_o`, both slot masks and `held_o` read 0. `issue_o` encodes 0 = none, 1 = older only, 2 = both. A slot mask has bit 0 for slot A and bit 1 for slot B.
- R2: An older code of 0 (empty) issues nothing. A younger code of 0 never pairs.
- R3: Slot B is never in use in a cycle unless slot A is also in use.
- R4: Two branch-type instructions never pair. The branch-type classes are 1 (direct branch) and 2 (call).
- R5: A call never pairs as the older member. When it issues alone it takes both slots (mask 3). As the younger member it takes slot B.
- R6: An older instruction of class 1, 3 (ALU immediate/extend/move), 4 (ALU register), 5 (ALU shifted), 7 (single-word load/store), 11 (scalar FP arithmetic) or 12 (FP-to-core transfer / single-precision FP load/store) pairs with a younger instruction of class 1, 2 or 3. The older then takes slot A (mask 1) and the younger takes slot B (mask 2). Any other younger class gives older-only issue with mask 1.
- R7: Classes 6 (multiply), 8 (double-word load/store), 9 (three-word block), 10 (four-word block), 13 (core-to-FP transfer), 14 (SIMD) and 15 (double FP load/store) always issue alone with mask 3.
- R8: When `yng_dep_i` is 1, the pair does not issue together.
- R9: `stall_i` forces no issue. `yng_stall_i` forces at most older-only issue.
- R10: In the cycle after a class 9 issues, `held_o` is 1. In the cycle after a class 10 issues, `held_o` is 3. Nothing issues in that cycle, and `held_o` returns to 0 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| old_cls_i | input | 4 | Class code of the older instruction |
| yng_cls_i | input | 4 | Class code of the younger instruction |
| yng_dep_i | input | 1 | Younger reads the older's destination |
| stall_i | input | 1 | Block all issue this cycle |
| yng_stall_i | input | 1 | Block issue of the younger this cycle |
| issue_o | output | 2 | 0 none, 1 older only, 2 both |
| old_slot_o | output | 2 | Slots taken by the older instruction |
| yng_slot_o | output | 2 | Slots taken by the younger instruction |
| held_o | output | 2 | Slots still held by a block transfer issued last cycle |

## Verification
The same-cycle assertions assume the combinational configuration. They also assume the class codes and flags are stable and known around each rising edge. The bench meets both conditions: it leaves `REG_OUT` at its default and changes inputs only on falling edges. It sweeps every pair of class codes against every combination of the dependency and stall flags. When a block transfer causes a held cycle, the bench checks that cycle and then replays the same input combination, so that no combination is hidden behind a hold.

// File: rtl/dual_issue_pair.sv
module dual_issue_pair #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] old_cls_i,
  input  logic [3:0] yng_cls_i,
  input  logic       yng_dep_i,
  input  logic       stall_i,
  input  logic       yng_stall_i,
  output logic [1:0] issue_o,
  output logic [1:0] old_slot_o,
  output logic [1:0] yng_slot_o,
  output logic [1:0] held_o
);
  localparam logic [3:0] C_NONE = 4'd0,  C_BR   = 4'd1,  C_CALL = 4'd2,  C_IMM  = 4'd3;
  localparam logic [3:0] C_AREG = 4'd4,  C_ASHF = 4'd5,  C_MUL  = 4'd6,  C_LS1  = 4'd7;
  localparam logic [3:0] C_LS2  = 4'd8,  C_LM3  = 4'd9,  C_LM4  = 4'd10, C_FPAR = 4'd11;
  localparam logic [3:0] C_FPS  = 4'd12, C_R2F  = 4'd13, C_SIMD = 4'd14, C_FPD  = 4'd15;

  function automatic logic lead_ok(input logic [3:0] c);
    return c inside {C_BR, C_IMM, C_AREG, C_ASHF, C_LS1, C_FPAR, C_FPS};
  endfunction

  function automatic logic trail_ok(input logic [3:0] c);
    return c inside {C_BR, C_CALL, C_IMM};
  endfunction

  function automatic logic branchy(input logic [3:0] c);
    return c inside {C_BR, C_CALL};
  endfunction

  function automatic logic wide(input logic [3:0] c);
    return c inside {C_CALL, C_MUL, C_LS2, C_LM3, C_LM4, C_R2F, C_SIMD, C_FPD};
  endfunction

  logic [1:0] held_q;
  logic       old_ok, pair_ok;
  logic [1:0] issue_d, old_slot_d, yng_slot_d;

  assign old_ok  = rst_n && !stall_i && (held_q == 2'b00) && (old_cls_i != C_NONE);
  assign pair_ok = old_ok && !yng_stall_i && !yng_dep_i && (yng_cls_i != C_NONE)
                   && lead_ok(old_cls_i) && trail_ok(yng_cls_i)
                   && !(branchy(old_cls_i) && branchy(yng_cls_i));

  assign issue_d    = pair_ok ? 2'd2 : (old_ok ? 2'd1 : 2'd0);
  assign old_slot_d = !old_ok ? 2'b00 : (pair_ok ? 2'b01 : (wide(old_cls_i) ? 2'b11 : 2'b01));
  assign yng_slot_d = pair_ok ? 2'b10 : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)                           held_q <= 2'b00;
    else if (old_ok && old_cls_i == C_LM3) held_q <= 2'b01;
    else if (old_ok && old_cls_i == C_LM4) held_q <= 2'b11;
    else                                  held_q <= 2'b00;
  end

  assign held_o = held_q;

  generate
    if (REG_OUT) begin : g_reg
      logic [1:0] issue_q, old_slot_q, yng_slot_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          issue_q    <= 2'd0;
          old_slot_q <= 2'b00;
          yng_slot_q <= 2'b00;
        end else begin
          issue_q    <= issue_d;
          old_slot_q <= old_slot_d;
          yng_slot_q <= yng_slot_d;
        end
      end
      assign issue_o    = issue_q;
      assign old_slot_o = old_slot_q;
      assign yng_slot_o = yng_slot_q;
    end else begin : g_comb
      assign issue_o    = issue_d;
      assign old_slot_o = old_slot_d;
      assign yng_slot_o = yng_slot_d;
    end
  endgenerate
endmodule

module dual_issue_pair_chk #(
  parameter bit REG_OUT = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] old_cls_i,
  input logic [3:0] yng_cls_i,
  input logic       yng_dep_i,
  input logic       stall_i,
  input logic       yng_stall_i,
  input logic [1:0] issue_o,
  input logic [1:0] old_slot_o,
  input logic [1:0] yng_slot_o,
  input logic [1:0] held_o
);
  logic [1:0] occ;
  assign occ = old_slot_o | yng_slot_o;

  // R3
  slot_b_needs_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ[1] |-> occ[0]);

  // R10
  held_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o != 2'b00) |=> (held_o == 2'b00));

  generate
    if (!REG_OUT) begin : g_same_cycle
      // R9
      stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> (issue_o == 2'd0));

      // R10
      held_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o != 2'b00) |-> (issue_o == 2'd0));

      // R4
      no_branch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_o == 2'd2) |-> !((old_cls_i inside {4'd1, 4'd2}) && (yng_cls_i inside {4'd1, 4'd2})));

      // R8
      dep_no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        yng_dep_i |-> (issue_o != 2'd2));

      // R5
      call_not_older_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (old_cls_i == 4'd2) |-> (issue_o != 2'd2));
    end
  endgenerate
endmodule

bind dual_issue_pair dual_issue_pair_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .old_cls_i(old_cls_i), .yng_cls_i(yng_cls_i),
  .yng_dep_i(yng_dep_i), .stall_i(stall_i), .yng_stall_i(yng_stall_i),
  .issue_o(issue_o), .old_slot_o(old_slot_o), .yng_slot_o(yng_slot_o), .held_o(held_o)
);

// File: tb/dual_issue_pair_tb.sv
module dual_issue_pair_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] old_cls_i = 4'd0, yng_cls_i = 4'd0;
  logic       yng_dep_i = 1'b0, stall_i = 1'b0, yng_stall_i = 1'b0;
  logic [1:0] issue_o, old_slot_o, yng_slot_o, held_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dual_issue_pair u_dut (
    .clk(clk), .rst_n(rst_n), .old_cls_i(old_cls_i), .yng_cls_i(yng_cls_i),
    .yng_dep_i(yng_dep_i), .stall_i(stall_i), .yng_stall_i(yng_stall_i),
    .issue_o(issue_o), .old_slot_o(old_slot_o), .yng_slot_o(yng_slot_o), .held_o(held_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d want %0d (old=%0d yng=%0d dep=%0b st=%0b yst=%0b)",
               req, what, act, exp, old_cls_i, yng_cls_i, yng_dep_i, stall_i, yng_stall_i);
    end
  endtask

  // class tables written from the requirement text (R5, R6, R7)
  function automatic bit can_lead(input int c);
    return (c == 1) || (c == 3) || (c == 4) || (c == 5) || (c == 7) || (c == 11) || (c == 12);
  endfunction
  function automatic bit can_trail(input int c);
    return (c >= 1) && (c <= 3);
  endfunction
  function automatic bit is_br(input int c);
    return (c == 1) || (c == 2);
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got 1 want 0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int idx;
    int exp_held;
    int o, y, dep, st, yst, exp_iss, exp_os, exp_ys, tag_dummy;
    string tag;
    // R1: reset state
    @(negedge clk);
    old_cls_i = 4'd3; yng_cls_i = 4'd3;
    #1;
    check("R1", "issue", issue_o, 0);
    check("R1", "old_slot", old_slot_o, 0);
    check("R1", "yng_slot", yng_slot_o, 0);
    @(negedge clk);
    old_cls_i = 4'd10;
    #1;
    check("R1", "held", held_o, 0);
    check("R1", "issue", issue_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    exp_held = 0;
    idx = 0;
    while (idx < 4096) begin
      o   = idx[11:8];
      y   = idx[7:4];
      dep = idx[2];
      st  = idx[1];
      yst = idx[0];
      old_cls_i = o[3:0]; yng_cls_i = y[3:0];
      yng_dep_i = dep[0]; stall_i = st[0]; yng_stall_i = yst[0];
      #1;
      exp_iss = 0; exp_os = 0; exp_ys = 0;
      if (exp_held != 0)      tag = "R10";
      else if (st != 0)       tag = "R9";
      else if (o == 0)        tag = "R2";
      else begin
        exp_iss = 1;
        exp_os  = can_lead(o) ? 1 : 3;
        if (yst != 0)                    tag = "R9";
        else if (y == 0)                 tag = "R2";
        else if (!can_lead(o))           tag = (o == 2) ? "R5" : "R7";
        else if (dep != 0)               tag = "R8";
        else if (is_br(o) && is_br(y))   tag = "R4";
        else if (!can_trail(y))          tag = "R6";
        else begin
          tag = (y == 2) ? "R5" : "R6";
          exp_iss = 2; exp_os = 1; exp_ys = 2;
        end
      end
      check(tag, "issue", issue_o, exp_iss);
      check(tag, "old_slot", old_slot_o, exp_os);
      check(tag, "yng_slot", yng_slot_o, exp_ys);
      check("R10", "held", held_o, exp_held);
      // R3: slot B only with slot A
      tag_dummy = int'(old_slot_o | yng_slot_o);
      check("R3", "slotB_without_A", ((tag_dummy & 2) != 0) && ((tag_dummy & 1) == 0), 0);
      if (exp_held == 0) idx++;
      if (exp_iss != 0 && o == 9)       exp_held = 1;
      else if (exp_iss != 0 && o == 10) exp_held = 3;
      else                              exp_held = 0;
      @(negedge clk);
    end
    #1;
    check("R10", "held_final", held_o, exp_held);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule